// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block turns a digitised supply-low flag and an active-low manual-reset request into a processor reset. The reset is available in both polarities. Once every cause has gone away, the reset is held for a fixed number of timebase ticks before it releases. A manual-reset request must stay low for a set number of clock cycles before it counts, so short glitches are dropped. All asynchronous inputs pass through a two-stage synchroniser. Timing is measured in ticks of an external timebase strobe, so the same logic covers millisecond periods on silicon and short periods in simulation.

A watchdog watches an activity line. Either a rising or a falling level change on that line restarts the watchdog count. The count also stays cleared while reset is active and while the system runs from its backup supply. If the line keeps one level for the full watchdog period, a fault occurs. A build-time mode picks what the fault does. In pulse mode it starts one full reset timeout. In separate mode it pulls a dedicated active-low fault line low. That line stays low until the next activity edge, a reset assertion, or entry into backup mode.

Top module: `sup_reset_wdog`

## Requirements
- R1: After the synchronous power-on reset input is released, reset is active (`rst_n_o`=0, `rst_o`=1), the fault line is high, and the watchdog count is zero.
- R2: A high `vlow_i` makes reset active within three clock cycles, and reset stays active while `vlow_i` is high.
- R3: A low level on `mr_n_i` activates reset only after it has held for `MR_FILT` consecutive clock cycles. A low pulse of fewer cycles has no effect on the reset outputs.
- R4: Reset releases on exactly the `RST_TICKS`-th tick strobe counted after the last cause has cleared, and not on any earlier tick.
- R5: `rst_o` is always the inverse of `rst_n_o`.
- R6: Either a rising or a falling level change on `wdi_i` restarts the watchdog count from zero.
- R7: A watchdog fault occurs on the `WD_TICKS`-th tick after the last restart, provided no restart happened in between. No fault occurs earlier.
- R8: In separate mode (`WD_MODE`=`WD_SEPARATE`), `wdf_n_o` falls on a fault. It stays low until the next `wdi_i` level change or until reset becomes active, and the reset outputs are unaffected by the fault.
- R9: In pulse mode (`WD_MODE`=`WD_PULSE`), a fault makes reset active and it then releases after `RST_TICKS` ticks. `wdf_n_o` stays high throughout.
- R10: While `bkup_i` is high, the watchdog count is held at zero, no fault occurs, and `wdf_n_o` returns high.
- R11: While reset is active, the watchdog count is held at zero.
- R12: When a `wdi_i` level change and the tick that would expire the period are seen in the same clock cycle, the level change wins: no fault occurs, and a full new period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | One-cycle timebase strobe, synchronous to clk |
| vlow_i | input | 1 | Supply-below-threshold flag, asynchronous |
| mr_n_i | input | 1 | Manual reset request, active low, asynchronous |
| wdi_i | input | 1 | Watchdog activity line, asynchronous |
| bkup_i | input | 1 | Backup-supply mode flag, asynchronous |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| wdf_n_o | output | 1 | Watchdog fault, active low (separate mode only) |

## Verification
The delicate overlap is an activity edge that reaches the watchdog in the same clock cycle as the tick that would end its period. The bench first runs the count to one tick short of expiry. It then changes `wdi_i` two clock cycles before raising `tick`, which lines up the synchronised edge and the strobe on one edge. It judges the outcome by checking that the fault line stays high for a further `WD_TICKS`-1 ticks and falls on the next one. A second overlap is a pulse-mode fault arriving while the count is being cleared by reset; it is covered by checking that exactly one reset timeout follows each fault.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Watchdog fault behaviour, chosen at build time
    typedef enum logic {
        WD_SEPARATE = 1'b0,
        WD_PULSE    = 1'b1
    } wd_mode_e;

    // Asynchronous inputs carried together through the synchroniser
    typedef struct packed {
        logic vlow;
        logic mr_n;
        logic wdi;
        logic bkup;
    } sup_in_t;

    // Value the synchroniser holds during power-on reset
    localparam sup_in_t SYNC_IDLE = '{vlow: 1'b0, mr_n: 1'b1, wdi: 1'b0, bkup: 1'b0};

    // Individual reset causes
    typedef struct packed {
        logic supply;
        logic manual;
        logic wdog;
    } rst_cause_t;

    // Per-cycle watchdog events
    typedef struct packed {
        logic toggle;
        logic clear;
        logic expire;
    } wd_evt_t;

    // Counter width able to hold 0 .. n-1
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter sup_pkg::sup_in_t IDLE = sup_pkg::SYNC_IDLE
) (
    input  logic             clk,
    input  logic             rst,
    input  sup_pkg::sup_in_t d,
    output sup_pkg::sup_in_t q
);
    sup_pkg::sup_in_t meta_q;
    sup_pkg::sup_in_t stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= IDLE;
            stab_q <= IDLE;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/sup_mr_filt.sv
module sup_mr_filt #(
    parameter int FILT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_n_s,
    output logic mr_act
);
    localparam int             CW   = sup_pkg::cnt_bits(FILT);
    localparam logic [CW-1:0]  LAST = CW'(FILT - 1);

    logic          level_n;
    logic [CW-1:0] run_cnt;

    // The filtered level follows the input only after FILT differing cycles in a row
    always_ff @(posedge clk) begin
        if (rst) begin
            level_n <= 1'b1;
            run_cnt <= '0;
        end else if (mr_n_s == level_n) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            level_n <= mr_n_s;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign mr_act = ~level_n;

    p_filt_change_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_n) |-> ($past(run_cnt) == LAST) && ($past(mr_n_s) != $past(level_n)));

    p_run_bound_r3: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= LAST);

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int                WD_TICKS = 1235,
    parameter sup_pkg::wd_mode_e MODE     = sup_pkg::WD_SEPARATE
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic wdi_s,
    input  logic bkup_s,
    input  logic rst_act,
    output logic fault_rst,
    output logic wdf_n
);
    localparam int            CW   = sup_pkg::cnt_bits(WD_TICKS);
    localparam logic [CW-1:0] LAST = CW'(WD_TICKS - 1);

    logic            wdi_q;
    logic [CW-1:0]   cnt;
    sup_pkg::wd_evt_t ev;

    always_ff @(posedge clk) begin
        if (rst) wdi_q <= 1'b0;
        else     wdi_q <= wdi_s;
    end

    // An edge, backup mode or active reset clears; clearing outranks expiry
    always_comb begin
        ev.toggle = wdi_s ^ wdi_q;
        ev.clear  = ev.toggle | bkup_s | rst_act;
        ev.expire = tick & ~ev.clear & (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || ev.clear) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    generate
        if (MODE == sup_pkg::WD_PULSE) begin : g_pulse
            assign fault_rst = ev.expire;
            assign wdf_n     = 1'b1;
        end else begin : g_sep
            logic flag_n;

            always_ff @(posedge clk) begin
                if (rst)             flag_n <= 1'b1;
                else if (ev.clear)   flag_n <= 1'b1;
                else if (ev.expire)  flag_n <= 1'b0;
            end

            assign fault_rst = 1'b0;
            assign wdf_n     = flag_n;

            p_flag_fall_r8: assert property (@(posedge clk) disable iff (rst)
                $fell(flag_n) |-> $past(tick) && ($past(wdi_s) == $past(wdi_q)) && !$past(rst_act));

            p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
                (!flag_n && (wdi_s == wdi_q) && !rst_act && !bkup_s) |=> !flag_n);

            p_bkup_flag_r10: assert property (@(posedge clk) disable iff (rst)
                bkup_s |=> flag_n);
        end
    endgenerate

endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
    parameter int RST_TICKS = 215
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  sup_pkg::rst_cause_t cause,
    output logic                rst_act
);
    localparam int            CW   = sup_pkg::cnt_bits(RST_TICKS);
    localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

    logic          any_cause;
    logic [CW-1:0] cnt;

    assign any_cause = |cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_act <= 1'b1;
            cnt     <= '0;
        end else if (any_cause) begin
            rst_act <= 1'b1;
            cnt     <= '0;
        end else if (rst_act && tick) begin
            if (cnt == LAST) begin
                rst_act <= 1'b0;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_cause_asserts_r2: assert property (@(posedge clk) disable iff (rst)
        any_cause |=> rst_act);

    p_release_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_act) |-> $past(tick) && !$past(any_cause) && ($past(cnt) == LAST));

    p_idle_count_r4: assert property (@(posedge clk) disable iff (rst)
        !rst_act |-> (cnt == '0));

endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog #(
    parameter int                RST_TICKS = 215,
    parameter int                WD_TICKS  = 1235,
    parameter int                MR_FILT   = 10,
    parameter sup_pkg::wd_mode_e WD_MODE   = sup_pkg::WD_SEPARATE
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic vlow_i,
    input  logic mr_n_i,
    input  logic wdi_i,
    input  logic bkup_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic wdf_n_o
);
    sup_pkg::sup_in_t   raw_in;
    sup_pkg::sup_in_t   syn_in;
    sup_pkg::rst_cause_t cause;
    logic               mr_act;
    logic               fault_rst;
    logic               rst_act;

    always_comb begin
        raw_in.vlow = vlow_i;
        raw_in.mr_n = mr_n_i;
        raw_in.wdi  = wdi_i;
        raw_in.bkup = bkup_i;
    end

    sup_sync #(.IDLE(sup_pkg::SYNC_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    sup_mr_filt #(.FILT(MR_FILT)) u_mr (
        .clk    (clk),
        .rst    (rst),
        .mr_n_s (syn_in.mr_n),
        .mr_act (mr_act)
    );

    sup_wdog #(.WD_TICKS(WD_TICKS), .MODE(WD_MODE)) u_wd (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wdi_s     (syn_in.wdi),
        .bkup_s    (syn_in.bkup),
        .rst_act   (rst_act),
        .fault_rst (fault_rst),
        .wdf_n     (wdf_n_o)
    );

    always_comb begin
        cause.supply = syn_in.vlow;
        cause.manual = mr_act;
        cause.wdog   = fault_rst;
    end

    sup_rst_timer #(.RST_TICKS(RST_TICKS)) u_rt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cause   (cause),
        .rst_act (rst_act)
    );

    assign rst_n_o = ~rst_act;
    assign rst_o   = rst_act;

    p_manual_reset_r3: assert property (@(posedge clk) disable iff (rst)
        mr_act |=> !rst_n_o);

endmodule

// File: tb/sim_sup_reset_wdog.sv
module sim_sup_reset_wdog;
    localparam int CLK_PERIOD = 10;
    localparam int RST_T      = 4;
    localparam int WD_T       = 6;
    localparam int MR_F       = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic vlow = 1'b0;
    logic mr_n = 1'b1;
    logic wdi  = 1'b0;
    logic bkup = 1'b1;
    logic s_rst_n, s_rst, s_wdf_n;
    logic p_rst_n, p_rst, p_wdf_n;
    int   n_tests = 0;
    int   n_fail  = 0;
    logic done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sup_reset_wdog #(.RST_TICKS(RST_T), .WD_TICKS(WD_T), .MR_FILT(MR_F),
                     .WD_MODE(sup_pkg::WD_SEPARATE)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .vlow_i(vlow), .mr_n_i(mr_n),
        .wdi_i(wdi), .bkup_i(bkup), .rst_n_o(s_rst_n), .rst_o(s_rst), .wdf_n_o(s_wdf_n));

    sup_reset_wdog #(.RST_TICKS(RST_T), .WD_TICKS(WD_T), .MR_FILT(MR_F),
                     .WD_MODE(sup_pkg::WD_PULSE)) u1 (
        .clk(clk), .rst(rst), .tick(tick), .vlow_i(vlow), .mr_n_i(mr_n),
        .wdi_i(wdi), .bkup_i(bkup), .rst_n_o(p_rst_n), .rst_o(p_rst), .wdf_n_o(p_wdf_n));

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Checks reset level and the polarity pair (R5) of one instance
    task automatic chk_rst(input string req, input string what, input logic rn, input logic rp, input logic exp_n);
        chk(req, what, rn, exp_n);
        chk("R5", {what, " polarity"}, rp, ~rn);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic toggle_wdi();
        @(negedge clk) wdi = ~wdi;
        settle();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL timeout: got hung run expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: power-on state
        chk_rst("R1", "sep reset at power-on", s_rst_n, s_rst, 1'b0);
        chk_rst("R1", "pulse reset at power-on", p_rst_n, p_rst, 1'b0);
        chk("R1", "sep fault line at power-on", s_wdf_n, 1'b1);
        chk("R1", "pulse fault line at power-on", p_wdf_n, 1'b1);
        settle();
        // R4: release timing from power-on, watchdogs idle in backup mode
        for (int k = 1; k <= RST_T; k++) begin
            ticks(1);
            chk_rst("R4", "power-on release", s_rst_n, s_rst, (k >= RST_T));
        end
        chk_rst("R4", "pulse power-on release", p_rst_n, p_rst, 1'b1);

        // R2 and R4: supply-low cause and release sweep
        @(negedge clk) vlow = 1'b1;
        repeat (3) @(negedge clk);
        chk_rst("R2", "supply low asserts", s_rst_n, s_rst, 1'b0);
        ticks(2 * RST_T);
        chk_rst("R2", "held while supply low", s_rst_n, s_rst, 1'b0);
        @(negedge clk) vlow = 1'b0;
        settle();
        for (int k = 1; k <= RST_T + 1; k++) begin
            ticks(1);
            chk_rst("R4", "supply release count", s_rst_n, s_rst, (k >= RST_T));
            chk_rst("R4", "pulse supply release", p_rst_n, p_rst, (k >= RST_T));
        end

        // R3: manual-reset width sweep
        for (int w = 1; w <= MR_F + 1; w++) begin
            @(negedge clk) mr_n = 1'b0;
            repeat (w) @(negedge clk);
            mr_n = 1'b1;
            repeat (MR_F + 6) @(negedge clk);
            chk_rst("R3", "manual pulse width", s_rst_n, s_rst, (w < MR_F));
            chk_rst("R3", "pulse manual pulse width", p_rst_n, p_rst, (w < MR_F));
            if (w >= MR_F) begin
                ticks(RST_T - 1);
                chk_rst("R4", "manual not yet released", s_rst_n, s_rst, 1'b0);
                ticks(1);
                chk_rst("R4", "manual released", s_rst_n, s_rst, 1'b1);
            end
        end

        // R7 and R8: watchdog sweep in separate mode
        @(negedge clk) bkup = 1'b0;
        settle();
        for (int n = 0; n <= WD_T + 1; n++) begin
            toggle_wdi();
            chk("R8", "edge releases fault line", s_wdf_n, 1'b1);
            ticks(n);
            chk("R7", "fault after n ticks", s_wdf_n, (n < WD_T));
            chk_rst("R8", "separate fault leaves reset", s_rst_n, s_rst, 1'b1);
        end

        // realign both instances out of reset
        @(negedge clk) bkup = 1'b1;
        settle();
        ticks(RST_T + 2);
        chk_rst("R10", "pulse idle in backup", p_rst_n, p_rst, 1'b1);
        @(negedge clk) bkup = 1'b0;
        settle();

        // R9: pulse mode
        toggle_wdi();
        ticks(WD_T - 1);
        chk_rst("R9", "no pulse before period", p_rst_n, p_rst, 1'b1);
        ticks(1);
        chk_rst("R9", "pulse reset on fault", p_rst_n, p_rst, 1'b0);
        chk("R9", "pulse mode fault line", p_wdf_n, 1'b1);
        chk("R8", "separate fault on same period", s_wdf_n, 1'b0);
        for (int k = 1; k <= RST_T; k++) begin
            ticks(1);
            chk_rst("R9", "pulse reset length", p_rst_n, p_rst, (k >= RST_T));
        end
        chk("R9", "pulse fault line after", p_wdf_n, 1'b1);

        // R11: reset holds the count clear
        toggle_wdi();
        ticks(WD_T - 1);
        chk("R11", "armed one tick short", s_wdf_n, 1'b1);
        @(negedge clk) vlow = 1'b1;
        settle();
        ticks(2);
        chk("R11", "no fault during reset", s_wdf_n, 1'b1);
        @(negedge clk) vlow = 1'b0;
        settle();
        ticks(RST_T);
        chk_rst("R4", "release after supply", s_rst_n, s_rst, 1'b1);
        ticks(WD_T - 1);
        chk("R11", "full period after reset", s_wdf_n, 1'b1);
        ticks(1);
        chk("R7", "fault after fresh period", s_wdf_n, 1'b0);

        // R10: backup mode
        @(negedge clk) bkup = 1'b1;
        settle();
        chk("R10", "backup releases fault line", s_wdf_n, 1'b1);
        ticks(2 * WD_T + RST_T);
        chk("R10", "no fault in backup", s_wdf_n, 1'b1);
        chk_rst("R10", "no pulse reset in backup", p_rst_n, p_rst, 1'b1);
        @(negedge clk) bkup = 1'b0;
        settle();

        // R8: reset assertion releases the fault line
        toggle_wdi();
        ticks(WD_T);
        chk("R8", "fault before reset", s_wdf_n, 1'b0);
        @(negedge clk) vlow = 1'b1;
        settle();
        chk("R8", "reset releases fault line", s_wdf_n, 1'b1);
        @(negedge clk) vlow = 1'b0;
        settle();
        ticks(RST_T);
        chk_rst("R4", "release after fault test", s_rst_n, s_rst, 1'b1);

        // R6: both edge directions restart the count
        toggle_wdi();
        ticks(WD_T - 1);
        toggle_wdi();
        ticks(WD_T - 1);
        chk("R6", "first direction restarts", s_wdf_n, 1'b1);
        toggle_wdi();
        ticks(WD_T - 1);
        chk("R6", "second direction restarts", s_wdf_n, 1'b1);

        // R12: edge and expiring tick in the same cycle
        @(negedge clk) wdi = ~wdi;
        @(negedge clk);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12", "edge beats expiry", s_wdf_n, 1'b1);
        ticks(WD_T - 1);
        chk("R12", "new period after clash", s_wdf_n, 1'b1);
        ticks(1);
        chk("R12", "fault at end of new period", s_wdf_n, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule